// File: doc/BRIEF.md
# SPI Memory Command Front End

This block is the serial front end of a memory-style SPI slave. The serial clock, chip enable and serial data input come in from pins. They are brought into the system clock domain through a short flop chain. Edges of the serial clock are then found by comparing the synchronised level against its previous value. The slave never produces a serial clock. It takes data on the SCK rising edge and changes its output on the SCK falling edge. Because it works from edges alone, a master that idles SCK low (mode 0) and one that idles it high (mode 3) are both served with no setting.

After chip enable falls, the first full byte is treated as an opcode. Two read commands are supported: a status read, which streams a status byte taken from an input port, and an identity read, which streams a fixed identity byte. Each read repeats its byte for as long as the device stays selected. Any other opcode is rejected. The slave then stops taking bits, keeps its data output released, and waits for a fresh falling edge of chip enable. A decoded-command output and a received-byte strobe let the rest of the device follow the transaction. The pad driver is built from `so_o` together with the output enable `so_oe`.

The serial clock half period must be at least SYNC_STAGES + 3 system clock cycles, so that every edge is seen before the next one arrives.

Top module: `spi_cmd_frontend`

## Requirements
- R1: SI is sampled on each SCK rising edge, most significant bit first. On every eighth rising edge of a selection, `byte_stb` pulses for exactly one system clock cycle, and `rx_byte` then holds the byte with the first received bit in bit 7.
- R2: The first byte after chip enable falls is decoded into `cmd_o`. The codes are: 0 = none, 1 = status read (opcode OPC_STATUS, default 0x05), 2 = identity read (opcode OPC_IDENT, default 0xAB), 3 = rejected (any other value). The code changes in the same cycle as the opcode's `byte_stb` pulse and then holds for the rest of the selection.
- R3: After a status-read opcode, SO carries `status_i` most significant bit first. The first bit appears on the SCK falling edge that follows the opcode's last rising edge. `status_i` is captured afresh at every byte boundary, and the byte repeats for as long as the device stays selected.
- R4: After an identity-read opcode, SO carries the parameter DEV_ID in the same way, repeated byte after byte.
- R5: While driven, `so_o` changes only in response to an SCK falling edge. Reads work with SCK idling low and with SCK idling high.
- R6: `so_oe` is high only during a status or identity read, from its first data falling edge onwards. It is low during opcode reception and while idle, and `so_o` is 0 whenever `so_oe` is low.
- R7: After a rejected opcode, for the rest of that selection no further byte is strobed, `so_oe` stays low and `cmd_o` stays 3.
- R8: Chip enable going high at any point, including mid-byte, returns the block to idle. `so_oe` and `cmd_o` fall to 0, and the bit counter is cleared, so the next selection starts byte alignment afresh.
- R9: Only a falling edge of chip enable opens a selection. Once a rejected opcode has locked the slave out, only a deselect followed by a new select lets it take an opcode again.
- R10: Bytes received on SI after a valid read opcode are still strobed on `byte_stb`/`rx_byte` while the read streams out (full duplex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master |
| ce_n | input | 1 | Chip enable, active low |
| si | input | 1 | Serial data into the slave |
| status_i | input | 8 | Status byte returned by the status read |
| so_o | output | 1 | Serial data out of the slave |
| so_oe | output | 1 | Output enable for the SO pad driver |
| cmd_o | output | 2 | Decoded command of the current selection |
| byte_stb | output | 1 | One-cycle pulse per received byte |
| rx_byte | output | 8 | Last received byte |

## Verification
The bench builds the block with SYNC_STAGES = 3 instead of the default 2, so every edge goes through the longest path the timing rule allows. This shows that SO still settles before the master's next sampling edge. DEV_ID is set to 0x6E, a value unlike the status patterns used. An identity read therefore cannot pass by returning status data, or the other way round. The opcodes stay at their defaults, so the near-miss rejected value 0x04 sits one bit away from the status opcode.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STATUS = 2'd1,
        CMD_IDENT  = 2'd2,
        CMD_REJECT = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPCODE = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_LOCKED = 2'd3
    } fe_state_e;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    // Map a received opcode onto a command code.
    function automatic cmd_e decode_opcode(
        input logic [BYTE_W-1:0] opc,
        input logic [BYTE_W-1:0] opc_status,
        input logic [BYTE_W-1:0] opc_ident
    );
        if (opc == opc_status) return CMD_STATUS;
        if (opc == opc_ident)  return CMD_IDENT;
        return CMD_REJECT;
    endfunction

    // Byte streamed out for a read command.
    function automatic logic [BYTE_W-1:0] read_word(
        input cmd_e              cmd,
        input logic [BYTE_W-1:0] status,
        input logic [BYTE_W-1:0] ident
    );
        case (cmd)
            CMD_STATUS: return status;
            CMD_IDENT:  return ident;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
    import spi_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              enable,
    input  logic              rise,
    input  logic              si,
    output logic              done,
    output logic [BYTE_W-1:0] word,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] rx_byte
);

    logic [BYTE_W-2:0]    shreg;
    logic [BIT_CNT_W-1:0] bit_cnt;

    // The byte completes on the edge that brings in its last bit.
    assign done = enable && rise && (bit_cnt == BIT_CNT_W'(BYTE_W - 1));
    assign word = {shreg, si};

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            byte_stb <= 1'b0;
            rx_byte  <= '0;
        end else begin
            byte_stb <= done;
            if (done) rx_byte <= word;
            if (clear) begin
                shreg   <= '0;
                bit_cnt <= '0;
            end else if (enable && rise) begin
                shreg   <= {shreg[BYTE_W-3:0], si};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
#(
    parameter logic [BYTE_W-1:0] OPC_STATUS = 8'h05,
    parameter logic [BYTE_W-1:0] OPC_IDENT  = 8'hAB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_high,
    input  logic              ce_fall,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] byte_word,
    output fe_state_e         state,
    output cmd_e              cmd_q,
    output cmd_e              cmd_dec,
    output logic              load
);

    assign cmd_dec = decode_opcode(byte_word, OPC_STATUS, OPC_IDENT);
    assign load    = (state == ST_OPCODE) && byte_done && (cmd_dec != CMD_REJECT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd_q <= CMD_NONE;
        end else if (ce_high) begin
            state <= ST_IDLE;
            cmd_q <= CMD_NONE;
        end else if (ce_fall) begin
            state <= ST_OPCODE;
            cmd_q <= CMD_NONE;
        end else if (state == ST_OPCODE && byte_done) begin
            cmd_q <= cmd_dec;
            state <= (cmd_dec == CMD_REJECT) ? ST_LOCKED : ST_ACTIVE;
        end
    end

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx
    import spi_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic              shift,
    input  logic [BYTE_W-1:0] word,
    output logic              so,
    output logic              oe
);

    logic [BYTE_W-1:0]    shreg;
    logic [BIT_CNT_W-1:0] bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
            so      <= 1'b0;
            oe      <= 1'b0;
        end else if (clear) begin
            shreg   <= '0;
            bit_cnt <= '0;
            so      <= 1'b0;
            oe      <= 1'b0;
        end else if (load) begin
            shreg   <= word;
            bit_cnt <= '0;
        end else if (shift) begin
            so      <= shreg[BYTE_W-1];
            oe      <= 1'b1;
            bit_cnt <= bit_cnt + 1'b1;
            // Refill at the byte boundary so the read repeats.
            if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) shreg <= word;
            else                                    shreg <= {shreg[BYTE_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
    import spi_fe_pkg::*;
#(
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  OPC_STATUS  = 8'h05,
    parameter logic [7:0]  OPC_IDENT   = 8'hAB,
    parameter logic [7:0]  DEV_ID      = 8'h9D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       ce_n,
    input  logic       si,
    input  logic [7:0] status_i,
    output logic       so_o,
    output logic       so_oe,
    output logic [1:0] cmd_o,
    output logic       byte_stb,
    output logic [7:0] rx_byte
);

    localparam int PIN_W = 3;
    localparam int IDX_SCK = 0;
    localparam int IDX_CE  = 1;
    localparam int IDX_SI  = 2;
    localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << IDX_CE;

    logic [PIN_W-1:0] pin_raw;
    logic [PIN_W-1:0] pin_s;
    logic             sck_d, ce_d;
    logic             sck_rise, sck_fall;
    logic             ce_high, ce_fall;

    assign pin_raw[IDX_SCK] = sck;
    assign pin_raw[IDX_CE]  = ce_n;
    assign pin_raw[IDX_SI]  = si;

    spi_fe_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
            ce_d  <= 1'b1;
        end else begin
            sck_d <= pin_s[IDX_SCK];
            ce_d  <= pin_s[IDX_CE];
        end
    end

    assign sck_rise = pin_s[IDX_SCK] & ~sck_d;
    assign sck_fall = ~pin_s[IDX_SCK] & sck_d;
    assign ce_high  = pin_s[IDX_CE];
    assign ce_fall  = ~pin_s[IDX_CE] & ce_d;

    fe_state_e         state;
    cmd_e              cmd_q, cmd_dec;
    logic              load;
    logic              rx_done;
    logic [BYTE_W-1:0] rx_word;
    logic [BYTE_W-1:0] tx_word;
    logic              rx_enable;

    assign rx_enable = (state == ST_OPCODE) || (state == ST_ACTIVE);

    spi_fe_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .clear    (ce_high | ce_fall),
        .enable   (rx_enable),
        .rise     (sck_rise),
        .si       (pin_s[IDX_SI]),
        .done     (rx_done),
        .word     (rx_word),
        .byte_stb (byte_stb),
        .rx_byte  (rx_byte)
    );

    spi_fe_ctrl #(
        .OPC_STATUS (OPC_STATUS),
        .OPC_IDENT  (OPC_IDENT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ce_high   (ce_high),
        .ce_fall   (ce_fall),
        .byte_done (rx_done),
        .byte_word (rx_word),
        .state     (state),
        .cmd_q     (cmd_q),
        .cmd_dec   (cmd_dec),
        .load      (load)
    );

    assign tx_word = load ? read_word(cmd_dec, status_i, DEV_ID)
                          : read_word(cmd_q, status_i, DEV_ID);

    spi_fe_tx u_tx (
        .clk   (clk),
        .rst   (rst),
        .clear (ce_high | ce_fall),
        .load  (load),
        .shift (sck_fall && (state == ST_ACTIVE)),
        .word  (tx_word),
        .so    (so_o),
        .oe    (so_oe)
    );

    assign cmd_o = cmd_q;

endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk (
    input logic       clk,
    input logic       rst,
    input logic       so_o,
    input logic       so_oe,
    input logic [1:0] cmd_o,
    input logic       byte_stb,
    input logic       ce_high,
    input logic       sck_fall
);

    assert_stb_single_R1: assert property (@(posedge clk) disable iff (rst)
        byte_stb |=> !byte_stb);

    assert_cmd_with_stb_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_o != 2'd0 && $past(cmd_o) == 2'd0) |-> byte_stb);

    assert_so_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (so_oe && $past(so_oe) && so_o != $past(so_o)) |-> $past(sck_fall));

    assert_oe_rise_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(so_oe) |-> $past(sck_fall));

    assert_oe_only_read_R6: assert property (@(posedge clk) disable iff (rst)
        so_oe |-> (cmd_o == 2'd1 || cmd_o == 2'd2));

    assert_quiet_when_off_R6: assert property (@(posedge clk) disable iff (rst)
        !so_oe |-> !so_o);

    assert_locked_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == 2'd3 && $past(cmd_o) == 2'd3) |-> !byte_stb);

    assert_idle_on_deselect_R8: assert property (@(posedge clk) disable iff (rst)
        ce_high |=> (!so_oe && cmd_o == 2'd0));

endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .so_o     (so_o),
    .so_oe    (so_oe),
    .cmd_o    (cmd_o),
    .byte_stb (byte_stb),
    .ce_high  (ce_high),
    .sck_fall (sck_fall)
);

// File: tb/spi_cmd_frontend_bench.sv
module spi_cmd_frontend_bench;

    localparam int         H      = 8;
    localparam logic [7:0] ID_VAL = 8'h6E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       ce_n = 1'b1;
    logic       si = 1'b0;
    logic [7:0] status_i = 8'h00;
    logic       so_o, so_oe, byte_stb;
    logic [1:0] cmd_o;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [1:0] so_q[$];
    logic [7:0] byte_q[$];

    always #4 clk = ~clk;

    spi_cmd_frontend #(
        .SYNC_STAGES (3),
        .DEV_ID      (ID_VAL)
    ) u_spi_cmd_frontend (
        .clk      (clk),
        .rst      (rst),
        .sck      (sck),
        .ce_n     (ce_n),
        .si       (si),
        .status_i (status_i),
        .so_o     (so_o),
        .so_oe    (so_oe),
        .cmd_o    (cmd_o),
        .byte_stb (byte_stb),
        .rx_byte  (rx_byte)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: SO and its enable, as seen by the master at each rising edge (R3 R4 R5 R6 R7).
    always @(posedge sck) begin
        if (!ce_n && so_q.size() > 0) begin
            logic [1:0] e;
            e = so_q.pop_front();
            chk({so_oe, so_o} == e, "R3/R4/R6", "so_oe,so_o at SCK rise",
                {so_oe, so_o}, e);
        end
    end

    // Monitor: received bytes (R1 R7 R10).
    always @(negedge clk) begin
        if (!rst && byte_stb) begin
            if (byte_q.size() == 0) begin
                chk(1'b0, "R7", "unexpected byte_stb, rx_byte", rx_byte, 0);
            end else begin
                logic [7:0] eb;
                eb = byte_q.pop_front();
                chk(rx_byte == eb, "R1", "rx_byte", rx_byte, eb);
            end
        end
    end

    // Driver: one selection of nbits, pushing expected results into the queues.
    task automatic xfer(input bit mode3, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] b2, input int nbits,
                        input logic [1:0] ecmd, input logic [7:0] dat);
        logic [7:0] bytes [3];
        bit reading;
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
        reading = (ecmd == 2'd1) || (ecmd == 2'd2);
        sck = mode3;
        tick(2 * H);
        ce_n = 1'b0;
        tick(H);
        for (int k = 0; k < nbits; k++) begin
            sck = 1'b0;
            si  = bytes[k / 8][7 - (k % 8)];
            if (k >= 8 && reading) so_q.push_back({1'b1, dat[7 - ((k - 8) % 8)]});
            else                   so_q.push_back(2'b00);
            if ((k % 8) == 7 && (k == 7 || reading)) byte_q.push_back(bytes[k / 8]);
            tick(H);
            sck = 1'b1;
            tick(H);
        end
        tick(2);
        if (nbits >= 8)
            chk(cmd_o == ecmd, "R2", "cmd_o during selection", cmd_o, ecmd);
        chk(byte_q.size() == 0, "R1", "bytes still pending", byte_q.size(), 0);
        if (!mode3) begin
            sck = 1'b0;
            tick(H);
        end
        ce_n = 1'b1;
        tick(H);
        chk(so_oe == 1'b0, "R8", "so_oe after deselect", so_oe, 0);
        chk(cmd_o == 2'd0, "R8", "cmd_o after deselect", cmd_o, 0);
        chk(so_q.size() == 0, "R5", "SO samples pending", so_q.size(), 0);
        so_q.delete();
        byte_q.delete();
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not complete", 0, 1);
        finish_run();
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(4);
        chk(so_oe == 1'b0, "R6", "so_oe after reset", so_oe, 0);
        chk(cmd_o == 2'd0, "R2", "cmd_o after reset", cmd_o, 0);
        chk(byte_stb == 1'b0, "R1", "byte_stb after reset", byte_stb, 0);

        // R3 R10: status read, SCK idle low, extra SI bytes strobed.
        status_i = 8'hA5;
        xfer(1'b0, 8'h05, 8'h3C, 8'h00, 24, 2'd1, 8'hA5);

        // R4 R5: identity read with SCK idling high.
        xfer(1'b1, 8'hAB, 8'hF0, 8'h81, 24, 2'd2, ID_VAL);

        // R7: rejected opcode, further bytes ignored.
        xfer(1'b0, 8'h77, 8'h05, 8'hAB, 24, 2'd3, 8'h00);

        // R9: fresh select after lockout takes an opcode again.
        status_i = 8'h5A;
        xfer(1'b1, 8'h05, 8'h12, 8'h00, 16, 2'd1, 8'h5A);

        // R8: opcode cut short after 5 bits, then alignment starts afresh.
        xfer(1'b0, 8'hAB, 8'h00, 8'h00, 5, 2'd0, 8'h00);
        xfer(1'b0, 8'hAB, 8'hC3, 8'h00, 16, 2'd2, ID_VAL);

        // R8: deselect in the middle of a data byte.
        status_i = 8'h96;
        xfer(1'b1, 8'h05, 8'h00, 8'h00, 11, 2'd1, 8'h96);

        // R7: near-miss opcode in mode 3.
        xfer(1'b1, 8'h04, 8'hFF, 8'h00, 16, 2'd3, 8'h00);

        // R3: status value captured afresh per selection.
        status_i = 8'h01;
        xfer(1'b0, 8'h05, 8'h00, 8'h00, 24, 2'd1, 8'h01);

        tick(10);
        finish_run();
    end

endmodule